// File: doc/BRIEF.md
# Time-Multiplexed Three-Read Two-Write Register File

This block presents a register file with three read ports and two write ports per target cycle. It is built on a single storage array that allows one read and one write per host clock. One target cycle is spread over three host clock cycles. The target clock is virtual: it advances only when the block reports that a target cycle has finished. The storage is split into equal banks that together form one flat address space. With the default parameters this gives three 2 KB banks of 64-bit words, 6 KB in total. None of the storage is built from flip-flops.

A requester presents three read addresses and two write requests on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls for the two cycles that follow acceptance. A request offered while `req_ready` is low is not taken and has no effect. The requester may hold it until `req_ready` returns, or withdraw it. Results leave without back-pressure: `done` pulses for one cycle, and `rd_data` then stays put until the next acceptance.

Writes are deferred. A target cycle's writes enter the array during the first two host slots of the next accepted target cycle. Until then, reads are served from a two-entry pending-write buffer. Reads therefore always see the array as it stood before the current target cycle.

Top module: `mprf_tdm`

## Requirements
- R1: After reset `req_ready` is 1, `busy` is 0, `done` is 0 and all three `rd_data` lanes are 0.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` high. `busy` is then high (and `req_ready` low) for exactly the next two cycles. A request offered while `busy` is high is not accepted and changes neither the array nor any result.
- R3: `done` is high for exactly one cycle: the third cycle after the acceptance edge, when `busy` is low again. A new request can be accepted in that same cycle, so one target cycle completes every three host cycles.
- R4: Each `rd_data` lane k returns the word at `rd_addr` lane k as it stood before any write of the same target cycle. This holds even when either write port targets that address.
- R5: Writes of a target cycle are seen by every read of any later target cycle, including the very next one.
- R6: If both write ports are enabled with the same address in one target cycle, the word stored is the one from write port 1 (lane 1 of `wr_data`).
- R7: A write lane whose `wr_en` bit is 0 leaves the array unchanged.
- R8: Valid addresses run from 0 to NUM_BANKS*BANK_DEPTH-1. Address a maps to bank a/BANK_DEPTH, entry a mod BANK_DEPTH. A read of a larger address returns 0, and a write to one has no effect on any stored word.
- R9: All request fields are sampled only at the acceptance edge. Changing them afterwards does not alter that target cycle's results or writes.
- R10: `rd_data` holds its value from the `done` cycle until the next acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Target-cycle request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| rd_addr | input | 3 x ADDR_W | Read addresses, lane k for read port k |
| wr_en | input | 2 | Write enables, bit j for write port j |
| wr_addr | input | 2 x ADDR_W | Write addresses, lane j for write port j |
| wr_data | input | 2 x DATA_W | Write data, lane j for write port j |
| busy | output | 1 | Target cycle in progress |
| done | output | 1 | One-cycle pulse: results on rd_data are valid |
| rd_data | output | 3 x DATA_W | Read results, lane k for read port k |

## Verification
The bench builds the block with DATA_W=16, BANK_DEPTH=8 and NUM_BANKS=3. That gives 24 valid words behind a 5-bit address, so 8 of the 32 codes fall outside the array. Random addresses therefore hit out-of-range decoding, bank-2 aliasing and same-address collisions between read and write ports, or between the two write ports, in most target cycles. The shallow array also lets the bench fill every word with a known value in a dozen back-to-back target cycles before random traffic starts.

// File: rtl/mprf_pkg.sv
package mprf_pkg;
  localparam int NUM_RD = 3;
  localparam int NUM_WR = 2;

  // Host slot within a target cycle; the slot-0 work is issued on the acceptance edge.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_1    = 2'd1,
    SLOT_2    = 2'd2
  } slot_e;
endpackage

// File: rtl/mprf_seq.sv
module mprf_seq
  import mprf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  output slot_e slot,
  output logic  done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= SLOT_IDLE;
      done <= 1'b0;
    end else begin
      done <= (slot == SLOT_2);
      unique case (slot)
        SLOT_IDLE: if (accept) slot <= SLOT_1;
        SLOT_1:    slot <= SLOT_2;
        SLOT_2:    slot <= SLOT_IDLE;
        default:   slot <= SLOT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mprf_store.sv
module mprf_store #(
  parameter int DATA_W     = 64,
  parameter int BANK_DEPTH = 256,
  parameter int NUM_BANKS  = 3,
  parameter int ADDR_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ENTRIES = NUM_BANKS * BANK_DEPTH;
  localparam int IDX_W   = $clog2(BANK_DEPTH);
  localparam int SEL_W   = ADDR_W - IDX_W;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ENTRIES);

  logic [IDX_W-1:0] r_idx, w_idx;
  logic [SEL_W-1:0] r_sel, w_sel, sel_q;
  logic             r_ok, w_ok, ok_q;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  assign r_idx = raddr[IDX_W-1:0];
  assign w_idx = waddr[IDX_W-1:0];
  assign r_sel = raddr[ADDR_W-1:IDX_W];
  assign w_sel = waddr[ADDR_W-1:IDX_W];
  assign r_ok  = {1'b0, raddr} < LIMIT;
  assign w_ok  = {1'b0, waddr} < LIMIT;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] arr [BANK_DEPTH];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we && w_ok && (w_sel == SEL_W'(b))) arr[w_idx] <= wdata;
    end

    // Registered read; returns the word as it was before a write on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (re && r_ok && (r_sel == SEL_W'(b))) q <= arr[r_idx];
    end

    assign bank_rd[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ok_q  <= 1'b0;
    end else if (re) begin
      sel_q <= r_sel;
      ok_q  <= r_ok;
    end
  end

  assign rdata = ok_q ? bank_rd[sel_q] : '0;
endmodule

// File: rtl/mprf_bypass.sv
module mprf_bypass
  import mprf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 10,
  parameter int ENTRIES = 768
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [NUM_WR-1:0]              ld_en,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  ld_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  ld_data,
  input  logic                           cm_go,
  input  logic                           cm_sel,
  output logic                           cm_en,
  output logic [ADDR_W-1:0]              cm_addr,
  output logic [DATA_W-1:0]              cm_data,
  input  logic                           look_en,
  input  logic [ADDR_W-1:0]              look_addr,
  output logic                           hit_q,
  output logic [DATA_W-1:0]              hit_data_q
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ENTRIES);

  logic [NUM_WR-1:0]             pv;
  logic [NUM_WR-1:0][ADDR_W-1:0] pa;
  logic [NUM_WR-1:0][DATA_W-1:0] pd;
  logic [NUM_WR-1:0]             match;
  logic                          look_ok, hit;
  logic [DATA_W-1:0]             hit_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      pa <= '0;
      pd <= '0;
    end else if (load) begin
      pv <= ld_en;
      pa <= ld_addr;
      pd <= ld_data;
    end
  end

  assign cm_en   = cm_go && pv[cm_sel];
  assign cm_addr = pa[cm_sel];
  assign cm_data = pd[cm_sel];

  assign look_ok = {1'b0, look_addr} < LIMIT;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_match
    assign match[p] = pv[p] && look_ok && (pa[p] == look_addr);
  end

  // Higher-numbered write port wins, matching commit order.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      if (match[p]) begin
        hit      = 1'b1;
        hit_data = pd[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q      <= 1'b0;
      hit_data_q <= '0;
    end else if (look_en) begin
      hit_q      <= hit;
      hit_data_q <= hit_data;
    end
  end
endmodule

// File: rtl/mprf_tdm.sv
module mprf_tdm
  import mprf_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int BANK_DEPTH = 256,
  parameter int NUM_BANKS  = 3,
  localparam int ENTRIES   = NUM_BANKS * BANK_DEPTH,
  localparam int ADDR_W    = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr,
  input  logic [NUM_WR-1:0]              wr_en,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data,
  output logic                           busy,
  output logic                           done,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);
  slot_e slot;
  logic  accept;

  logic [ADDR_W-1:0]             lat_ra1, lat_ra2;
  logic [NUM_WR-1:0]             lat_we;
  logic [NUM_WR-1:0][ADDR_W-1:0] lat_wa;
  logic [NUM_WR-1:0][DATA_W-1:0] lat_wd;

  logic              mem_re, cm_go, cm_sel, cm_en, hit_q;
  logic [ADDR_W-1:0] mem_raddr, cm_addr;
  logic [DATA_W-1:0] cm_data, mem_rdata, hit_data_q, res0_q, res1_q;

  assign busy      = (slot != SLOT_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  mprf_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .slot   (slot),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_ra1 <= '0;
      lat_ra2 <= '0;
      lat_we  <= '0;
      lat_wa  <= '0;
      lat_wd  <= '0;
    end else if (accept) begin
      lat_ra1 <= rd_addr[1];
      lat_ra2 <= rd_addr[2];
      lat_we  <= wr_en;
      lat_wa  <= wr_addr;
      lat_wd  <= wr_data;
    end
  end

  // Read slot k: port 0 straight from the request on acceptance, then the latched ports.
  always_comb begin
    mem_re    = accept || busy;
    mem_raddr = lat_ra2;
    if (accept)               mem_raddr = rd_addr[0];
    else if (slot == SLOT_1)  mem_raddr = lat_ra1;
  end

  // Pending writes of the previous target cycle drain in slots 0 and 1.
  assign cm_go  = accept || (slot == SLOT_1);
  assign cm_sel = (slot == SLOT_1);

  mprf_bypass #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES)
  ) u_byp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (slot == SLOT_2),
    .ld_en      (lat_we),
    .ld_addr    (lat_wa),
    .ld_data    (lat_wd),
    .cm_go      (cm_go),
    .cm_sel     (cm_sel),
    .cm_en      (cm_en),
    .cm_addr    (cm_addr),
    .cm_data    (cm_data),
    .look_en    (cm_go),
    .look_addr  (mem_raddr),
    .hit_q      (hit_q),
    .hit_data_q (hit_data_q)
  );

  mprf_store #(
    .DATA_W     (DATA_W),
    .BANK_DEPTH (BANK_DEPTH),
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .re    (mem_re),
    .raddr (mem_raddr),
    .we    (cm_en),
    .waddr (cm_addr),
    .wdata (cm_data),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res0_q <= '0;
      res1_q <= '0;
    end else begin
      if (slot == SLOT_1) res0_q <= hit_q ? hit_data_q : mem_rdata;
      if (slot == SLOT_2) res1_q <= hit_q ? hit_data_q : mem_rdata;
    end
  end

  // Slot 2 runs after both pending writes have landed, so it needs no forwarding.
  assign rd_data[0] = res0_q;
  assign rd_data[1] = res1_q;
  assign rd_data[2] = mem_rdata;
endmodule

// File: rtl/mprf_tdm_chk.sv
module mprf_tdm_chk #(
  parameter int DATA_W = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  busy,
  input logic                  done,
  input logic [2:0][DATA_W-1:0] rd_data
);
  logic hold_q;
  logic acc;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= 1'b0;
    else if (acc)   hold_q <= 1'b0;
    else if (done)  hold_q <= 1'b1;
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  a_r2_busy_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  a_r2_not_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_results_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((hold_q || done) && !acc) |=> $stable(rd_data));
endmodule

bind mprf_tdm mprf_tdm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data)
);

// File: tb/tb_mprf_tdm.sv
module tb_mprf_tdm;
  localparam int DW  = 16;
  localparam int BD  = 8;
  localparam int NB  = 3;
  localparam int ENT = NB * BD;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready, busy, done;
  logic [2:0][AW-1:0] rd_addr = '0;
  logic [1:0]         wr_en = '0;
  logic [1:0][AW-1:0] wr_addr = '0;
  logic [1:0][DW-1:0] wr_data = '0;
  logic [2:0][DW-1:0] rd_data;

  always #2 clk = ~clk;

  mprf_tdm #(.DATA_W(DW), .BANK_DEPTH(BD), .NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference: a plain 3-read/2-write array with target-cycle semantics.
  logic [DW-1:0] ref_mem [ENT];
  int            m_phase = 0;
  bit            m_have = 0;
  logic [DW-1:0] exp_rd [3];
  string         req_tag = "R4";
  string         exp_tag = "R4";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      m_have  = 0;
    end else begin
      if (req_valid && (m_phase == 0 || m_phase == 3)) begin
        for (int k = 0; k < 3; k++)
          exp_rd[k] = (int'(rd_addr[k]) < ENT) ? ref_mem[rd_addr[k]] : '0;
        for (int j = 0; j < 2; j++)
          if (wr_en[j] && int'(wr_addr[j]) < ENT) ref_mem[wr_addr[j]] = wr_data[j];
        exp_tag = req_tag;
        m_phase = 1;
        m_have  = 0;
      end else if (m_phase == 1) m_phase = 2;
      else if (m_phase == 2) m_phase = 3;
      else if (m_phase == 3) begin
        m_phase = 0;
        m_have  = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == (m_phase == 1 || m_phase == 2), "R2", "busy", busy, (m_phase == 1 || m_phase == 2));
      check(req_ready == (m_phase == 0 || m_phase == 3), "R2", "req_ready", req_ready, (m_phase == 0 || m_phase == 3));
      check(done == (m_phase == 3), "R3", "done", done, (m_phase == 3));
      if (m_phase == 3) begin
        for (int k = 0; k < 3; k++)
          check(rd_data[k] === exp_rd[k], exp_tag, $sformatf("rd_data[%0d]", k), rd_data[k], exp_rd[k]);
      end else if (m_phase == 0 && m_have) begin
        for (int k = 0; k < 3; k++)
          check(rd_data[k] === exp_rd[k], "R10", $sformatf("held rd_data[%0d]", k), rd_data[k], exp_rd[k]);
      end
    end
  end

  task automatic junk();
    rd_addr = {AW'($urandom), AW'($urandom), AW'($urandom)};
    wr_en   = 2'($urandom);
    wr_addr = {AW'($urandom), AW'($urandom)};
    wr_data = {DW'($urandom), DW'($urandom)};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      junk();
    end
  endtask

  task automatic send(input string tag, input int ra0, input int ra1, input int ra2,
                      input bit we0, input int wa0, input int wd0,
                      input bit we1, input int wa1, input int wd1);
    forever begin
      @(negedge clk);
      req_valid  = 1'b1;
      req_tag    = tag;
      rd_addr[0] = AW'(ra0); rd_addr[1] = AW'(ra1); rd_addr[2] = AW'(ra2);
      wr_en      = {we1, we0};
      wr_addr[0] = AW'(wa0); wr_addr[1] = AW'(wa1);
      wr_data[0] = DW'(wd0); wr_data[1] = DW'(wd1);
      if (m_phase == 0 || m_phase == 3) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) ref_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    for (int k = 0; k < 3; k++)
      check(rd_data[k] === '0, "R1", "rd_data", rd_data[k], 0);

    // Fill every word back to back (R3 throughput); reads out of range give 0 (R8).
    for (int i = 0; i < ENT / 2; i++)
      send("R8", 31, 30, 29, 1, 2*i, 16'h1000 + 2*i, 1, 2*i+1, 16'h1000 + 2*i+1);
    idle(4);

    // R4: same-cycle writes are invisible to all three read ports.
    send("R4", 3, 4, 3, 1, 4, 16'hAAAA, 1, 3, 16'hBBBB);
    // R5: the very next target cycle sees both writes, port 0 included.
    send("R5", 3, 4, 4, 0, 0, 0, 0, 0, 0);
    idle(2);

    // R6: both write ports on one address; port 1 wins.
    send("R6", 5, 5, 5, 1, 5, 16'h1111, 1, 5, 16'h2222);
    send("R6", 5, 5, 5, 0, 0, 0, 0, 0, 0);
    idle(3);
    send("R6", 6, 5, 6, 1, 6, 16'h3333, 1, 6, 16'h4444);
    idle(5);
    send("R6", 6, 6, 6, 0, 0, 0, 0, 0, 0);

    // R7: disabled write lanes leave the word alone.
    send("R7", 7, 8, 9, 0, 7, 16'hDEAD, 0, 8, 16'hBEEF);
    send("R7", 7, 8, 9, 0, 0, 0, 0, 0, 0);

    // R8: out-of-range write must not alias into bank 0, bank 2 decodes correctly.
    send("R8", 24, 0, 20, 1, 24, 16'h5555, 1, 20, 16'h6666);
    send("R8", 24, 0, 20, 1, 28, 16'h7777, 0, 0, 0);
    send("R8", 28, 20, 0, 0, 0, 0, 0, 0, 0);
    idle(2);

    // R2: a request shown only while busy is never taken.
    send("R2", 10, 11, 12, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      wr_en = 2'b11; wr_addr[0] = AW'(10); wr_addr[1] = AW'(11);
      wr_data[0] = 16'hCAFE; wr_data[1] = 16'hF00D;
    end
    @(negedge clk);
    req_valid = 1'b0;
    send("R2", 10, 11, 12, 0, 0, 0, 0, 0, 0);
    idle(2);

    // R9: fields altered right after acceptance have no effect.
    send("R9", 13, 14, 15, 1, 13, 16'h0A0A, 1, 14, 16'h0B0B);
    idle(3);
    send("R9", 13, 14, 15, 0, 0, 0, 0, 0, 0);
    // R10: results held across a long idle with changing inputs.
    send("R10", 16, 17, 18, 0, 0, 0, 0, 0, 0);
    idle(8);

    // Random traffic with forced collisions, compared every cycle (R4).
    for (int n = 0; n < 400; n++) begin
      int a0, a1, a2, w0, w1, sel;
      a0 = $urandom % 32; a1 = $urandom % 32; a2 = $urandom % 32;
      w0 = $urandom % 32; w1 = $urandom % 32;
      sel = $urandom % 4;
      if (sel == 0) w1 = w0;
      if (sel == 1) begin a0 = w1; a2 = w0; end
      if (sel == 2) begin a1 = w0; a2 = w1; end
      send("R4", a0, a1, a2, 1'($urandom), w0, int'($urandom % 65536),
           1'($urandom), w1, int'($urandom % 65536));
      if ($urandom % 3 == 0) idle($urandom % 4);
    end
    idle(6);
    finish_run();
  end
endmodule